// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder

This block turns a four-bit binary-coded decimal digit into the seven signals that drive a numeric display. The segments are named a through g and are active high. A storage register in front of the decoder keeps a copy of the digit. While the capture control is low, the register takes a new digit on every rising clock edge. When the control goes high, the register keeps the last digit it took, so the upstream bus is free for other traffic and the display stays steady.

Two active-low overrides act only on the output stage. The lamp-test input turns every segment on, so all lamps can be inspected. The blanking input turns every segment off, for example to suppress leading zeros. Lamp test has priority over blanking. Neither override changes the stored digit, so the held digit returns as soon as both overrides are released. Digit codes above nine show nothing. The six is drawn without its top bar and the nine without its bottom bar.

Top module: `bcd_seg_latch`

## Requirements
- R1: A synchronous active-high reset clears the stored digit to 0. After reset, with both overrides inactive, the output is 7'b1111110.
- R2: On each rising edge where `holdEn` is low, the register loads `digitIn`. The new pattern appears on `segOut` after that edge.
- R3: On each rising edge where `holdEn` is high, the stored digit is kept. `segOut` does not change while `digitIn` moves.
- R4: While `testN` is low, `segOut` is 7'b1111111 in the same cycle, whatever `blankN`, `holdEn` and the stored digit are.
- R5: While `testN` is high and `blankN` is low, `segOut` is 7'b0000000 in the same cycle.
- R6: `testN` and `blankN` never alter the stored digit. Once both are high again, the digit held before the override is shown.
- R7: With both overrides inactive, `segOut` = {a,b,c,d,e,f,g}, with a in bit 6 and g in bit 0. Digits 0 to 9 give 1111110, 0110000, 1101101, 1111001, 0110011, 1011011, 0011111, 1110000, 1111111 and 1110011.
- R8: With both overrides inactive, stored codes 10 to 15 give 7'b0000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| holdEn | input | 1 | High holds the stored digit; low loads `digitIn` each edge |
| blankN | input | 1 | Active-low blanking of all segments |
| testN | input | 1 | Active-low lamp test, all segments on |
| digitIn | input | 4 | BCD digit to capture |
| segOut | output | 7 | Segment drives, bit 6 = a down to bit 0 = g, active high |

## Verification
A digit loaded with `holdEn` low passes through one register. Its pattern is due just after the next rising edge. The bench drives every input on a falling edge and samples one time unit after the following rising edge. The overrides are combinational, so their results are due in the same cycle. For rows that only change `testN` or `blankN` with `holdEn` high, the bench still samples after that edge, and the edge must not change the stored digit. The hold and override rows follow a loaded digit in the same vector sequence, so each hold check compares against the pattern captured earlier.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDigit;
    logic lampAll;
    logic blankAll;
  } segStrobes_t;

  // segment image for one stored code, bit 6 = a .. bit 0 = g
  function automatic logic [SEG_W-1:0] glyphOf(input logic [DIGIT_W-1:0] code);
    logic [SEG_W-1:0] img;
    case (code)
      4'd0:    img = 7'b1111110;
      4'd1:    img = 7'b0110000;
      4'd2:    img = 7'b1101101;
      4'd3:    img = 7'b1111001;
      4'd4:    img = 7'b0110011;
      4'd5:    img = 7'b1011011;
      4'd6:    img = 7'b0011111;
      4'd7:    img = 7'b1110000;
      4'd8:    img = 7'b1111111;
      4'd9:    img = 7'b1110011;
      default: img = '0;  // non-decimal codes stay dark
    endcase
    return img;
  endfunction
endpackage

// File: rtl/segdec_ctrl.sv
module segdec_ctrl
  import segdec_pkg::*;
(
  input  logic        holdEn,
  input  logic        blankN,
  input  logic        testN,
  output segStrobes_t strobes
);
  always_comb begin
    strobes.loadDigit = ~holdEn;
    // lamp test wins over blanking
    strobes.lampAll   = ~testN;
    strobes.blankAll  = testN & ~blankN;
  end
endmodule

// File: rtl/segdec_datapath.sv
module segdec_datapath
  import segdec_pkg::*;
#(
  parameter int DW = DIGIT_W,
  parameter int SW = SEG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  segStrobes_t   strobes,
  input  logic [DW-1:0] digitIn,
  output logic [DW-1:0] digitQ,
  output logic [SW-1:0] segOut
);
  logic [SW-1:0] glyph;

  // storage stage; overrides never reach it
  always_ff @(posedge clk) begin
    if (rst)                    digitQ <= '0;
    else if (strobes.loadDigit) digitQ <= digitIn;
  end

  always_comb glyph = glyphOf(digitQ);

  always_comb begin
    if (strobes.lampAll)       segOut = '1;
    else if (strobes.blankAll) segOut = '0;
    else                       segOut = glyph;
  end
endmodule

// File: rtl/bcd_seg_latch.sv
module bcd_seg_latch
  import segdec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               holdEn,
  input  logic               blankN,
  input  logic               testN,
  input  logic [DIGIT_W-1:0] digitIn,
  output logic [SEG_W-1:0]   segOut
);
  segStrobes_t        strobes;
  logic [DIGIT_W-1:0] storedDigit;

  segdec_ctrl ctrl (
    .holdEn (holdEn),
    .blankN (blankN),
    .testN  (testN),
    .strobes(strobes)
  );

  segdec_datapath #(.DW(DIGIT_W), .SW(SEG_W)) dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .digitIn(digitIn),
    .digitQ (storedDigit),
    .segOut (segOut)
  );
endmodule

// File: rtl/segdec_checker.sv
module segdec_checker
  import segdec_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               holdEn,
  input logic               blankN,
  input logic               testN,
  input logic [DIGIT_W-1:0] digitIn,
  input logic [DIGIT_W-1:0] digitQ,
  input logic [SEG_W-1:0]   segOut
);
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> digitQ == '0);

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    !holdEn |=> digitQ == $past(digitIn));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    holdEn |=> $stable(digitQ));

  assert_lamp_R4: assert property (@(posedge clk) disable iff (rst)
    !testN |-> segOut == '1);

  assert_blank_R5: assert property (@(posedge clk) disable iff (rst)
    (testN && !blankN) |-> segOut == '0);

  assert_override_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (holdEn && (!testN || !blankN)) |=> digitQ == $past(digitQ));

  assert_nondecimal_dark_R8: assert property (@(posedge clk) disable iff (rst)
    (testN && blankN && digitQ > 4'd9) |-> segOut == '0);
endmodule

bind bcd_seg_latch segdec_checker chk (
  .clk    (clk),
  .rst    (rst),
  .holdEn (holdEn),
  .blankN (blankN),
  .testN  (testN),
  .digitIn(digitIn),
  .digitQ (storedDigit),
  .segOut (segOut)
);

// File: tb/bcd_seg_latch_test.sv
module bcd_seg_latch_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       holdEn = 1'b1;
  logic       blankN = 1'b1;
  logic       testN = 1'b1;
  logic [3:0] digitIn = 4'd0;
  logic [6:0] segOut;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic       le;
    logic       bl;
    logic       lt;
    logic [3:0] d;
    logic [6:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [0:NV-1] = '{
    // R7 decimal glyphs
    '{1'b0,1'b1,1'b1,4'd0, 7'b1111110,4'd7},
    '{1'b0,1'b1,1'b1,4'd1, 7'b0110000,4'd7},
    '{1'b0,1'b1,1'b1,4'd2, 7'b1101101,4'd7},
    '{1'b0,1'b1,1'b1,4'd3, 7'b1111001,4'd7},
    '{1'b0,1'b1,1'b1,4'd4, 7'b0110011,4'd7},
    '{1'b0,1'b1,1'b1,4'd5, 7'b1011011,4'd7},
    '{1'b0,1'b1,1'b1,4'd6, 7'b0011111,4'd7},
    '{1'b0,1'b1,1'b1,4'd7, 7'b1110000,4'd7},
    '{1'b0,1'b1,1'b1,4'd8, 7'b1111111,4'd7},
    '{1'b0,1'b1,1'b1,4'd9, 7'b1110011,4'd7},
    // R8 non-decimal codes
    '{1'b0,1'b1,1'b1,4'd10,7'b0000000,4'd8},
    '{1'b0,1'b1,1'b1,4'd11,7'b0000000,4'd8},
    '{1'b0,1'b1,1'b1,4'd12,7'b0000000,4'd8},
    '{1'b0,1'b1,1'b1,4'd13,7'b0000000,4'd8},
    '{1'b0,1'b1,1'b1,4'd14,7'b0000000,4'd8},
    '{1'b0,1'b1,1'b1,4'd15,7'b0000000,4'd8},
    // R2 load 4, R3 hold it while data moves
    '{1'b0,1'b1,1'b1,4'd4, 7'b0110011,4'd2},
    '{1'b1,1'b1,1'b1,4'd7, 7'b0110011,4'd3},
    // R5 blank, R4 lamp beats blank, R6 stored 4 returns
    '{1'b1,1'b0,1'b1,4'd7, 7'b0000000,4'd5},
    '{1'b1,1'b0,1'b0,4'd2, 7'b1111111,4'd4},
    '{1'b1,1'b1,1'b1,4'd2, 7'b0110011,4'd6},
    // R5 blank while loading 9, R6 9 shown after release
    '{1'b0,1'b0,1'b1,4'd9, 7'b0000000,4'd5},
    '{1'b1,1'b1,1'b1,4'd3, 7'b1110011,4'd6}
  };

  bcd_seg_latch uut (
    .clk(clk), .rst(rst), .holdEn(holdEn), .blankN(blankN),
    .testN(testN), .digitIn(digitIn), .segOut(segOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [6:0] exp, input string tag);
    checks++;
    if (segOut !== exp) begin
      errors++;
      $display("FAIL %s segOut=%b expected=%b", tag, segOut, exp);
    end
  endtask

  // drive on falling edge, sample 1 unit after next rising edge
  task automatic step(input logic le, input logic bl, input logic lt, input logic [3:0] d);
    @(negedge clk);
    holdEn = le; blankN = bl; testN = lt; digitIn = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        step(1'b1, 1'b1, 1'b1, 4'd5);
        check(7'b1111110, "R1 reset digit shows 0");
        step(1'b1, 1'b1, 1'b1, 4'd6);
        check(7'b1111110, "R3 hold after reset");

        for (int i = 0; i < NV; i++) begin
          step(VECS[i].le, VECS[i].bl, VECS[i].lt, VECS[i].d);
          check(VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R4: lamp test is immediate within one cycle, no edge needed
        @(negedge clk);
        holdEn = 1'b1; testN = 1'b0; blankN = 1'b1;
        #1 check(7'b1111111, "R4 lamp same cycle");
        testN = 1'b1; blankN = 1'b0;
        #1 check(7'b0000000, "R5 blank same cycle");
        blankN = 1'b1;
        #1 check(7'b1110011, "R6 held 9 after same-cycle overrides");

        // R1: reset while holding 8 clears to 0
        step(1'b0, 1'b1, 1'b1, 4'd8);
        check(7'b1111111, "R2 load 8");
        @(negedge clk) begin rst = 1'b1; holdEn = 1'b1; end
        @(posedge clk); #1;
        @(negedge clk) rst = 1'b0;
        #1 check(7'b1111110, "R1 reset during hold");
      end
      begin
        repeat (2000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule